// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a timer. The counter, its compare latch and the channel-0 period event sit outside the channel. In capture mode the channel picks one of four input sources. It detects the chosen edge on that source, either on the raw level or after a two-stage synchronizer, and stores the current counter value. It also raises a pending flag, and it raises an overflow flag when a new capture arrives before the previous one has been serviced.

In compare mode the channel turns the moment the counter reaches the compare value into a one-cycle equality event. That event, together with the period event from channel 0, drives a registered waveform output through one of eight output modes. The pending flag is set by captures in capture mode and by equality events in compare mode. The interrupt request is that flag gated by an enable.

Top module: `ccx_channel`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cap_val`, `out_pin`, `flag`, `ovf`, `in_lvl` and `irq` become 0.
- R2: `in_sel` picks the capture source: 0 gives `in_a`, 1 gives `in_b`, 2 gives constant 0, 3 gives constant 1. `in_lvl` shows the selected level one clock after it is sampled.
- R3: `cap_edge` encodes 0 no capture, 1 rising edge, 2 falling edge, 3 both edges. A capture happens only while `cap_mode` is 1. At all other times `cap_val` holds its value.
- R4: With `sync_en` 0, an input edge is detected at the first clock edge that samples the new level. `cap_val` then takes the `cnt_val` present at that clock edge.
- R5: With `sync_en` 1, the edge passes through two synchronizer flops before detection. The capture happens two clock edges later than with `sync_en` 0 and stores the `cnt_val` of that later edge.
- R6: `flag` is set by a capture when `cap_mode` is 1, and by an equality event when `cap_mode` is 0. It stays set until `flag_clr` is 1 at a clock edge. A set in the same cycle as a clear wins.
- R7: `ovf` is set when a capture occurs while `flag` is 1 and `flag_clr` is not asserted in that cycle. It stays set until `ovf_clr` is applied. A set in the same cycle as a clear wins.
- R8: An equality event occurs in the cycle where `cnt_val` equals `cmp_val` and did not equal it in the previous cycle. Holding equality gives only one event.
- R9: When `out_mode` is 0, `out_pin` takes `out_bit` at each clock edge.
- R10: Modes 1 (set), 4 (toggle) and 5 (reset) act on the equality event only. `per_eq` has no effect in these modes.
- R11: In modes 2 (toggle/reset), 3 (set/reset), 6 (toggle/set) and 7 (reset/set), the first action is taken on the equality event and the second on `per_eq`. When both events arrive in the same cycle, the second action decides the output.
- R12: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | W | Current counter value |
| cmp_val | input | W | Latched compare value |
| per_eq | input | 1 | Channel-0 equality (period) event, one-cycle pulse |
| cap_mode | input | 1 | 1 capture, 0 compare |
| cap_edge | input | 2 | Capture edge select |
| in_sel | input | 2 | Capture source select |
| sync_en | input | 1 | 1 selects the synchronized capture path |
| in_a | input | 1 | Capture source A |
| in_b | input | 1 | Capture source B |
| out_mode | input | 3 | Output mode |
| out_bit | input | 1 | Output level used in mode 0 |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the pending flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| cap_val | output | W | Captured counter value |
| in_lvl | output | 1 | Registered selected input level |
| out_pin | output | 1 | Waveform output |
| flag | output | 1 | Capture/compare pending flag |
| ovf | output | 1 | Capture overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
If the edge detector holds a stale previous level, a capture is lost or doubled. That shows on `cap_val` and `flag` at the very next clock edge. A synchronizer of the wrong depth shifts the captured count by one for every missing or extra stage, so the bench compares the exact count against a free-running counter. A wrong equality history or output-mode decode shows on `out_pin` one clock after the offending event. Pairs of events in the same cycle are driven on purpose so that priority errors appear.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef enum logic [2:0] {
    OM_BIT     = 3'd0,
    OM_SET     = 3'd1,
    OM_TOG_RST = 3'd2,
    OM_SET_RST = 3'd3,
    OM_TOG     = 3'd4,
    OM_RST     = 3'd5,
    OM_TOG_SET = 3'd6,
    OM_RST_SET = 3'd7
  } out_mode_e;
endpackage

// File: rtl/ccx_capture_in.sv
module ccx_capture_in
  import ccx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_a,
  input  logic       in_b,
  input  logic [1:0] in_sel,
  input  logic       sync_en,
  input  logic [1:0] edge_sel,
  output logic       cap_evt,
  output logic       lvl_q
);
  localparam int LAST = SYNC_STAGES - 1;

  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sdly_q;
  logic                   cur, prv, rise, fall;

  always_comb begin
    unique case (in_sel)
      2'd0:    raw = in_a;
      2'd1:    raw = in_b;
      2'd2:    raw = 1'b0;
      default: raw = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      sync_q <= '0;
      sdly_q <= 1'b0;
    end else begin
      lvl_q  <= raw;
      sync_q <= {sync_q[LAST-1:0], raw};
      sdly_q <= sync_q[LAST];
    end
  end

  // raw path compares against last sample; synced path against delayed last stage
  assign cur  = sync_en ? sync_q[LAST] : raw;
  assign prv  = sync_en ? sdly_q : lvl_q;
  assign rise = cur & ~prv;
  assign fall = ~cur & prv;

  always_comb begin
    unique case (edge_sel_e'(edge_sel))
      EDGE_RISE: cap_evt = rise;
      EDGE_FALL: cap_evt = fall;
      EDGE_BOTH: cap_evt = rise | fall;
      default:   cap_evt = 1'b0;
    endcase
  end

  a_r2_ground_no_edge: assert property (@(posedge clk) disable iff (rst)
    (in_sel == 2'd2 && $past(in_sel) == 2'd2 && !sync_en) |-> !cap_evt)
    else $error("R2: constant-low source produced an edge");

  a_r3_none_no_evt: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == 2'd0) |-> !cap_evt)
    else $error("R3: edge select none produced an event");
endmodule

// File: rtl/ccx_cmp_detect.sv
module ccx_cmp_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         eq_evt
);
  logic match, match_q;

  assign match  = (cnt == cmp);
  assign eq_evt = match & ~match_q;

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= match;
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    eq_evt |=> !eq_evt)
    else $error("R8: equality event lasted more than one cycle");
endmodule

// File: rtl/ccx_out_unit.sv
module ccx_out_unit
  import ccx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       out_bit,
  input  logic       eq_evt,
  input  logic       per_evt,
  output logic       out_q
);
  logic nxt;

  always_comb begin
    nxt = out_q;
    unique case (out_mode_e'(mode))
      OM_BIT: nxt = out_bit;
      OM_SET: if (eq_evt) nxt = 1'b1;
      OM_TOG: if (eq_evt) nxt = ~out_q;
      OM_RST: if (eq_evt) nxt = 1'b0;
      OM_TOG_RST: begin
        if (eq_evt)  nxt = ~out_q;
        if (per_evt) nxt = 1'b0;
      end
      OM_SET_RST: begin
        if (eq_evt)  nxt = 1'b1;
        if (per_evt) nxt = 1'b0;
      end
      OM_TOG_SET: begin
        if (eq_evt)  nxt = ~out_q;
        if (per_evt) nxt = 1'b1;
      end
      default: begin
        if (eq_evt)  nxt = 1'b0;
        if (per_evt) nxt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= nxt;
  end

  a_r9_bit_follow: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0) |=> (out_q == $past(out_bit)))
    else $error("R9: output did not follow software bit");

  a_r10_set_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd1 && out_q) |=> out_q)
    else $error("R10: set mode dropped the output");

  a_r11_period_reset: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd2 || mode == 3'd3) && per_evt) |=> !out_q)
    else $error("R11: period event did not reset output");

  a_r11_period_set: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd6 || mode == 3'd7) && per_evt) |=> out_q)
    else $error("R11: period event did not set output");
endmodule

// File: rtl/ccx_channel.sv
module ccx_channel #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_val,
  input  logic         per_eq,
  input  logic         cap_mode,
  input  logic [1:0]   cap_edge,
  input  logic [1:0]   in_sel,
  input  logic         sync_en,
  input  logic         in_a,
  input  logic         in_b,
  input  logic [2:0]   out_mode,
  input  logic         out_bit,
  input  logic         irq_en,
  input  logic         flag_clr,
  input  logic         ovf_clr,
  output logic [W-1:0] cap_val,
  output logic         in_lvl,
  output logic         out_pin,
  output logic         flag,
  output logic         ovf,
  output logic         irq
);
  logic         cap_evt, eq_evt, take, set_flag;
  logic [W-1:0] cap_q;
  logic         flag_q, ovf_q;

  ccx_capture_in #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_sel(in_sel),
    .sync_en(sync_en), .edge_sel(cap_edge), .cap_evt(cap_evt), .lvl_q(in_lvl)
  );

  ccx_cmp_detect #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt_val), .cmp(cmp_val), .eq_evt(eq_evt)
  );

  ccx_out_unit u_out (
    .clk(clk), .rst(rst), .mode(out_mode), .out_bit(out_bit),
    .eq_evt(eq_evt), .per_evt(per_eq), .out_q(out_pin)
  );

  assign take     = cap_mode & cap_evt;
  assign set_flag = cap_mode ? cap_evt : eq_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (take) cap_q <= cnt_val;
      flag_q <= set_flag | (flag_q & ~flag_clr);
      ovf_q  <= (take & flag_q & ~flag_clr) | (ovf_q & ~ovf_clr);
    end
  end

  assign cap_val = cap_q;
  assign flag    = flag_q;
  assign ovf     = ovf_q;
  assign irq     = flag_q & irq_en;

  a_r7_ovf_needs_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(flag_q))
    else $error("R7: overflow without a pending flag");

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr) |=> ovf_q)
    else $error("R7: overflow cleared without request");

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q)
    else $error("R6: flag cleared without request");

  a_r3_hold_in_compare: assert property (@(posedge clk) disable iff (rst)
    !cap_mode |=> $stable(cap_q))
    else $error("R3: capture register changed in compare mode");
endmodule

// File: tb/test_ccx_channel.sv
module test_ccx_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] free_cnt = '0;
  logic [W-1:0] man_cnt = '0;
  logic         use_free = 1'b1;
  logic [W-1:0] cnt_val, cmp_val;
  logic         per_eq = 1'b0, cap_mode = 1'b0, sync_en = 1'b0;
  logic [1:0]   cap_edge = 2'd0, in_sel = 2'd0;
  logic         in_a = 1'b0, in_b = 1'b0;
  logic [2:0]   out_mode = 3'd0;
  logic         out_bit = 1'b0, irq_en = 1'b0, flag_clr = 1'b0, ovf_clr = 1'b0;
  logic [W-1:0] cap_val;
  logic         in_lvl, out_pin, flag, ovf, irq;
  int           n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) free_cnt <= free_cnt + 1'b1;
  assign cnt_val = use_free ? free_cnt : man_cnt;
  assign cmp_val = 16'd20;

  ccx_channel #(.W(W), .SYNC_STAGES(2)) i_ccx_channel (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cmp_val(cmp_val), .per_eq(per_eq),
    .cap_mode(cap_mode), .cap_edge(cap_edge), .in_sel(in_sel), .sync_en(sync_en),
    .in_a(in_a), .in_b(in_b), .out_mode(out_mode), .out_bit(out_bit),
    .irq_en(irq_en), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
    .cap_val(cap_val), .in_lvl(in_lvl), .out_pin(out_pin), .flag(flag),
    .ovf(ovf), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1; ovf_clr = 1'b1; step();
    flag_clr = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 cap_val", cap_val, 0); chk("R1 out_pin", out_pin, 0);
    chk("R1 flag", flag, 0); chk("R1 ovf", ovf, 0);
    chk("R1 irq", irq, 0); chk("R1 in_lvl", in_lvl, 0);
    rst = 1'b0;
  endtask

  task automatic t_insel();
    in_a = 1'b1; in_b = 1'b0;
    in_sel = 2'd0; step(); chk("R2 sel A", in_lvl, 1);
    in_sel = 2'd1; step(); chk("R2 sel B", in_lvl, 0);
    in_sel = 2'd2; step(); chk("R2 sel low", in_lvl, 0);
    in_sel = 2'd3; step(); chk("R2 sel high", in_lvl, 1);
    in_sel = 2'd0; in_a = 1'b0; step(4);
  endtask

  task automatic t_async_cap();
    logic [W-1:0] e;
    cap_mode = 1'b1; sync_en = 1'b0; cap_edge = 2'd1; step(2); clear_flags();
    e = free_cnt; in_a = 1'b1; step();
    chk("R4 async capture value", cap_val, e); chk("R6 flag on capture", flag, 1);
    chk("R7 no ovf first", ovf, 0);
    e = cap_val; in_a = 1'b0; step();
    chk("R3 rising ignores fall", cap_val, e);
    cap_edge = 2'd2; in_a = 1'b1; step();
    chk("R3 falling ignores rise", cap_val, e);
    e = free_cnt; in_a = 1'b0; step();
    chk("R3 falling capture", cap_val, e); chk("R7 ovf set", ovf, 1);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk("R7 ovf cleared", ovf, 0);
    cap_edge = 2'd3;
    e = free_cnt; in_a = 1'b1; step(); chk("R3 both rise", cap_val, e);
    e = free_cnt; in_a = 1'b0; step(); chk("R3 both fall", cap_val, e);
    cap_edge = 2'd0; e = cap_val; in_a = 1'b1; step(); in_a = 1'b0; step();
    chk("R3 none no capture", cap_val, e);
    cap_edge = 2'd3; cap_mode = 1'b0; e = cap_val; in_a = 1'b1; step(); in_a = 1'b0; step();
    chk("R3 compare mode no capture", cap_val, e);
  endtask

  task automatic t_ovf_race();
    logic [W-1:0] e;
    cap_mode = 1'b1; cap_edge = 2'd1; sync_en = 1'b0; in_a = 1'b0; step(2); clear_flags();
    in_a = 1'b1; step(); chk("R6 flag set", flag, 1);
    in_a = 1'b0; step();
    flag_clr = 1'b1; in_a = 1'b1; step(); flag_clr = 1'b0;
    chk("R6 set wins over clear", flag, 1); chk("R7 no ovf when cleared", ovf, 0);
    in_a = 1'b0; step();
    in_a = 1'b1; step(); chk("R7 ovf on pending", ovf, 1);
    in_a = 1'b0; step();
    ovf_clr = 1'b1; in_a = 1'b1; step(); ovf_clr = 1'b0;
    chk("R7 set wins over clear", ovf, 1);
    irq_en = 1'b0; step(); chk("R12 irq gated", irq, 0);
    irq_en = 1'b1; #1; chk("R12 irq raised", irq, 1);
    flag_clr = 1'b1; step(); flag_clr = 1'b0; chk("R6 flag cleared", flag, 0);
    chk("R12 irq low after clear", irq, 0);
    irq_en = 1'b0; in_a = 1'b0; step(); clear_flags();
    e = '0;
  endtask

  task automatic t_sync_cap();
    logic [W-1:0] e;
    cap_mode = 1'b1; sync_en = 1'b1; cap_edge = 2'd1; in_a = 1'b0; step(4); clear_flags();
    e = free_cnt + 16'd2; in_a = 1'b1;
    step(2); chk("R5 not yet captured", flag, 0);
    step(); chk("R5 sync capture value", cap_val, e); chk("R5 flag", flag, 1);
    sync_en = 1'b0; in_a = 1'b0; step(4); clear_flags();
  endtask

  task automatic preset(input logic v);
    out_mode = 3'd0; out_bit = v; step();
    chk("R9 out follows bit", out_pin, v);
  endtask

  task automatic evt(input logic own, input logic per);
    man_cnt = 16'd0; step();
    man_cnt = own ? 16'd20 : 16'd0; per_eq = per; step();
    per_eq = 1'b0;
  endtask

  task automatic t_single();
    cap_mode = 1'b0; use_free = 1'b0; man_cnt = 16'd0; step(); clear_flags();
    preset(1'b0); preset(1'b1); preset(1'b0);
    out_mode = 3'd1; evt(1'b0, 1'b1); chk("R10 set ignores period", out_pin, 0);
    evt(1'b1, 1'b0); chk("R10 set on equality", out_pin, 1);
    chk("R6 flag on compare", flag, 1);
    out_mode = 3'd5; evt(1'b0, 1'b1); chk("R10 reset ignores period", out_pin, 1);
    evt(1'b1, 1'b0); chk("R10 reset on equality", out_pin, 0);
    out_mode = 3'd4; evt(1'b1, 1'b0); chk("R10 toggle 1", out_pin, 1);
    step(); chk("R8 held equality no retoggle", out_pin, 1);
    evt(1'b1, 1'b0); chk("R10 toggle 2", out_pin, 0);
    evt(1'b0, 1'b1); chk("R10 toggle ignores period", out_pin, 0);
  endtask

  task automatic t_dual();
    preset(1'b0); out_mode = 3'd3;
    evt(1'b1, 1'b0); chk("R11 set/reset first", out_pin, 1);
    evt(1'b0, 1'b1); chk("R11 set/reset second", out_pin, 0);
    preset(1'b1); out_mode = 3'd7;
    evt(1'b1, 1'b0); chk("R11 reset/set first", out_pin, 0);
    evt(1'b0, 1'b1); chk("R11 reset/set second", out_pin, 1);
    preset(1'b0); out_mode = 3'd2;
    evt(1'b1, 1'b0); chk("R11 toggle/reset first", out_pin, 1);
    evt(1'b0, 1'b1); chk("R11 toggle/reset second", out_pin, 0);
    preset(1'b0); out_mode = 3'd6;
    evt(1'b1, 1'b0); chk("R11 toggle/set first", out_pin, 1);
    evt(1'b1, 1'b0); chk("R11 toggle/set toggles", out_pin, 0);
    evt(1'b0, 1'b1); chk("R11 toggle/set second", out_pin, 1);
    preset(1'b0); out_mode = 3'd3;
    evt(1'b1, 1'b1); chk("R11 coincident set/reset", out_pin, 0);
    preset(1'b0); out_mode = 3'd7;
    evt(1'b1, 1'b1); chk("R11 coincident reset/set", out_pin, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_insel();
    t_async_cap();
    t_ovf_race();
    t_sync_cap();
    t_single();
    t_dual();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule